// File: doc/BRIEF.md
# Byte ALU with Direction-Selecting Rotate and Boolean Compares

This block is the 8-bit arithmetic and logic unit of a small processor. On each cycle where the request strobe is high, it takes two operand bytes and a 5-bit operation code. The operation code is the instruction opcode number, passed through without remapping. One clock later the unit presents the registered result together with a single-cycle result-valid pulse.

The unit covers these operations:
- add and subtract, with wrap-around;
- the three bitwise operations;
- zero-filling shifts in both directions and a sign-filling right shift;
- a rotate whose direction is chosen by the size of the amount;
- two comparisons that produce the byte 0x01 or 0x00, so that a register can hold them, rather than setting flags.

The immediate-add opcode goes through the same adder as register add. Opcodes that the unit does not handle produce 0x00.

Top module: `byte_alu`

## Requirements
- R1: While reset is asserted and right after it is released, `res_valid` is 0 and `res_data` is 0x00.
- R2: Opcode 4 (register add) and opcode 6 (immediate add) both give (a + b) mod 256.
- R3: Opcode 5 gives (a - b) mod 256, so with a = 0xFF the result is the bitwise inverse of b.
- R4: Opcode 7 gives a AND b, opcode 8 gives a OR b, and opcode 9 gives a XOR b.
- R5: Opcode 10 shifts a left by b and opcode 11 shifts a right by b, both filling with zeros. Any b of 8 or more gives 0x00.
- R6: Opcode 12 shifts a right by b and fills with copies of a[7]. Any b of 8 or more gives 0xFF when a[7] is 1 and 0x00 otherwise.
- R7: Opcode 13 rotates a. When b is 8 or less, it rotates right by b mod 8, so b = 8 returns a unchanged. When b is above 8, it rotates left by (b - 8) mod 8.
- R8: Opcode 22 gives 0x01 when a < b, compared as unsigned numbers, and 0x00 otherwise.
- R9: Opcode 23 gives 0x01 when a == b and 0x00 otherwise.
- R10: `res_valid` is high in exactly the cycle after each cycle with `req_valid` high, and `res_data` carries that request's result in that same cycle. Back-to-back requests produce back-to-back results.
- R11: When `req_valid` is low, operand and opcode changes have no effect, and `res_data` keeps its last value.
- R12: Any opcode not listed above gives 0x00, and the result-valid pulse still follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; operands and opcode are sampled when high |
| req_op | input | 5 | Operation code (instruction opcode number) |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand, also the shift or rotate amount |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 8 | Registered result |

## Verification
The bench concentrates on shift and rotate amounts at and above the byte width:
- A shifter that uses only the low three bits of the count returns a shifted copy of a for counts of 8 or 200, where zero or sign fill is required.
- A rotate that does not switch direction above 8, or that gets the left amount wrong, shows up in the 0x81 by 9, 0x01 by 11 and 0x5A by 16 cases.
- Rotate by exactly 8 must return its input.

Comparisons use operands with the top bit set, so a signed compare gives the wrong answer. Wrap-around cases in add and subtract check that the carry is dropped. Idle cycles with changing inputs check that the result register holds, and back-to-back requests check that no pulse is lost or stretched.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd4,
        OP_SUB  = 5'd5,
        OP_ADDI = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_SHL  = 5'd10,
        OP_SHR  = 5'd11,
        OP_SRA  = 5'd12,
        OP_ROT  = 5'd13,
        OP_CLT  = 5'd22,
        OP_CEQ  = 5'd23
    } alu_op_e;

endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [W-1:0] diff,
    output logic         lt,
    output logic         eq
);
    always_comb begin
        sum  = a + b;
        diff = a - b;
        lt   = (a < b);
        eq   = (a == b);
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o
);
    always_comb begin
        and_o = a & b;
        or_o  = a | b;
        xor_o = a ^ b;
    end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] shl_o,
    output logic [W-1:0] shr_o,
    output logic [W-1:0] sra_o,
    output logic [W-1:0] rot_o
);
    localparam int CW = $clog2(W);
    localparam logic [W-1:0] LIMIT = W[W-1:0];

    logic          wide;
    logic [CW-1:0] cnt;
    logic [W-1:0]  over;
    logic [CW-1:0] lamt;
    logic [CW-1:0] ramt;
    logic [2*W-1:0] dbl;

    always_comb begin
        wide = (b >= LIMIT);
        cnt  = b[CW-1:0];
        shl_o = wide ? '0 : (a << cnt);
        shr_o = wide ? '0 : (a >> cnt);
        sra_o = wide ? {W{a[W-1]}} : W'($signed(a) >>> cnt);
        // direction chosen by amount: up to W turns right, above W turns left
        over = b - LIMIT;
        lamt = over[CW-1:0];
        ramt = (b <= LIMIT) ? cnt : (CW'(0) - lamt);
        dbl  = {a, a} >> ramt;
        rot_o = dbl[W-1:0];
    end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int W   = 8,
    parameter int OPW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [OPW-1:0] req_op,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    output logic           res_valid,
    output logic [W-1:0]   res_data
);
    localparam logic [W-1:0] LIMIT = W[W-1:0];

    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] sum_w, diff_w, and_w, or_w, xor_w;
    logic [W-1:0] shl_w, shr_w, sra_w, rot_w;
    logic         lt_w, eq_w;

    alu_arith_unit #(.W(W)) u_arith (
        .a(opnd_a), .b(opnd_b), .sum(sum_w), .diff(diff_w), .lt(lt_w), .eq(eq_w)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .a(opnd_a), .b(opnd_b), .and_o(and_w), .or_o(or_w), .xor_o(xor_w)
    );

    alu_shift_unit #(.W(W)) u_shift (
        .a(opnd_a), .b(opnd_b), .shl_o(shl_w), .shr_o(shr_w),
        .sra_o(sra_w), .rot_o(rot_w)
    );

    logic [W-1:0] pick_w;

    always_comb begin
        case (req_op)
            OP_ADD, OP_ADDI: pick_w = sum_w;
            OP_SUB:          pick_w = diff_w;
            OP_AND:          pick_w = and_w;
            OP_OR:           pick_w = or_w;
            OP_XOR:          pick_w = xor_w;
            OP_SHL:          pick_w = shl_w;
            OP_SHR:          pick_w = shr_w;
            OP_SRA:          pick_w = sra_w;
            OP_ROT:          pick_w = rot_w;
            OP_CLT:          pick_w = W'(lt_w);
            OP_CEQ:          pick_w = W'(eq_w);
            default:         pick_w = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.data = pick_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.vld;
    assign res_data  = st_q.data;

    // adder and subtractor agree with each other
    p_add_inverse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_w - opnd_b) == opnd_a);
    p_sub_inverse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_w + opnd_b) == opnd_a);
    p_shl_wide_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_b >= LIMIT) |-> (shl_w == '0 && shr_w == '0));
    p_sra_wide_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_b >= LIMIT) |-> (sra_w == {W{opnd_a[W-1]}}));
    p_rot_full_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_b == LIMIT) |-> (rot_w == opnd_a));
    p_cmp_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lt_w, eq_w}));
    p_cmp_bool_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OP_CLT || req_op == OP_CEQ)) |=> (res_data <= W'(1)));
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    p_valid_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(res_data));

endmodule

// File: tb/byte_alu_tb.sv
module byte_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [4:0] req_op = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic       res_valid;
    logic [7:0] res_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    byte_alu u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid), .res_data(res_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [4:0] op,
                          input logic [7:0] a, input logic [7:0] b, input logic [7:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, {7'd0, res_valid}, 8'h01);
        chk(tag, res_data, exp);
    endtask

    task automatic t_reset_r1();
        chk("R1 valid", {7'd0, res_valid}, 8'h00);
        chk("R1 data", res_data, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", {7'd0, res_valid}, 8'h00);
        chk("R1 data after release", res_data, 8'h00);
    endtask

    task automatic t_arith_r2_r3();
        run_op("R2 add carry into msb", 5'd4, 8'h7F, 8'h01, 8'h80);
        run_op("R2 add wrap", 5'd4, 8'hFF, 8'h02, 8'h01);
        run_op("R2 immediate add", 5'd6, 8'h10, 8'h05, 8'h15);
        run_op("R3 sub borrow", 5'd5, 8'h05, 8'h07, 8'hFE);
        run_op("R3 sub ones complement", 5'd5, 8'hFF, 8'h3C, 8'hC3);
    endtask

    task automatic t_logic_r4();
        run_op("R4 and", 5'd7, 8'hF0, 8'h3C, 8'h30);
        run_op("R4 or",  5'd8, 8'hF0, 8'h3C, 8'hFC);
        run_op("R4 xor", 5'd9, 8'hF0, 8'h3C, 8'hCC);
    endtask

    task automatic t_shift_r5_r6();
        run_op("R5 shl by 1", 5'd10, 8'h81, 8'd1, 8'h02);
        run_op("R5 shl by 7", 5'd10, 8'h01, 8'd7, 8'h80);
        run_op("R5 shl by 8", 5'd10, 8'hFF, 8'd8, 8'h00);
        run_op("R5 shr by 7", 5'd11, 8'h80, 8'd7, 8'h01);
        run_op("R5 shr by 200", 5'd11, 8'hFF, 8'd200, 8'h00);
        run_op("R6 sra negative", 5'd12, 8'h80, 8'd2, 8'hE0);
        run_op("R6 sra positive", 5'd12, 8'h40, 8'd2, 8'h10);
        run_op("R6 sra wide negative", 5'd12, 8'h80, 8'd9, 8'hFF);
        run_op("R6 sra wide positive", 5'd12, 8'h7F, 8'd255, 8'h00);
    endtask

    task automatic t_rotate_r7();
        run_op("R7 rotate right 1", 5'd13, 8'h01, 8'd1, 8'h80);
        run_op("R7 rotate right 4", 5'd13, 8'h12, 8'd4, 8'h21);
        run_op("R7 rotate by 0", 5'd13, 8'h5A, 8'd0, 8'h5A);
        run_op("R7 rotate by 8", 5'd13, 8'h96, 8'd8, 8'h96);
        run_op("R7 rotate left via 9", 5'd13, 8'h81, 8'd9, 8'h03);
        run_op("R7 rotate left via 11", 5'd13, 8'h01, 8'd11, 8'h08);
        run_op("R7 rotate left via 16", 5'd13, 8'h5A, 8'd16, 8'h5A);
    endtask

    task automatic t_compare_r8_r9();
        run_op("R8 less", 5'd22, 8'h03, 8'h05, 8'h01);
        run_op("R8 unsigned high bit", 5'd22, 8'h80, 8'h7F, 8'h00);
        run_op("R8 equal not less", 5'd22, 8'h05, 8'h05, 8'h00);
        run_op("R9 equal", 5'd23, 8'hAA, 8'hAA, 8'h01);
        run_op("R9 unequal", 5'd23, 8'hAA, 8'hAB, 8'h00);
    endtask

    task automatic t_pulse_r10();
        @(negedge clk);
        req_valid = 1'b1; req_op = 5'd4; opnd_a = 8'h01; opnd_b = 8'h01;
        @(negedge clk);
        chk("R10 first valid", {7'd0, res_valid}, 8'h01);
        chk("R10 first data", res_data, 8'h02);
        req_op = 5'd9; opnd_a = 8'h0F; opnd_b = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 second valid", {7'd0, res_valid}, 8'h01);
        chk("R10 second data", res_data, 8'hF0);
        @(negedge clk);
        chk("R10 pulse ends", {7'd0, res_valid}, 8'h00);
    endtask

    task automatic t_idle_r11();
        run_op("R11 setup", 5'd8, 8'h30, 8'h03, 8'h33);
        req_op = 5'd4; opnd_a = 8'h11; opnd_b = 8'h22;
        @(negedge clk);
        req_op = 5'd13; opnd_a = 8'hFF; opnd_b = 8'h01;
        @(negedge clk);
        chk("R11 hold data", res_data, 8'h33);
        chk("R11 no valid", {7'd0, res_valid}, 8'h00);
    endtask

    task automatic t_unknown_r12();
        run_op("R12 opcode 0", 5'd0, 8'h05, 8'h05, 8'h00);
        run_op("R12 opcode 31", 5'd31, 8'hFF, 8'h01, 8'h00);
        run_op("R12 opcode 14", 5'd14, 8'h42, 8'h00, 8'h00);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset_r1();
        t_arith_r2_r3();
        t_logic_r4();
        t_shift_r5_r6();
        t_rotate_r7();
        t_compare_r8_r9();
        t_pulse_r10();
        t_idle_r11();
        t_unknown_r12();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule